// File: doc/BRIEF.md
# Channel-Status Bit Access Port

This block lets a host reach a 32-bit digital audio channel-status word one bit at a time over a small synchronous register bus. The bus has two registers. The control/status register, at address 0, sets the direction of the next data-register access when written. When read, it reports what the receiver front end sees: clock presence, data presence and a decoded sample-rate code. The data register, at address 1, holds a bit index in its low five bits and a bit value in bit 7.

A host first writes the direction. In write direction, each data-register write stores one bit at the given index, so a full word update takes 32 writes with indices 0 to 31. In read direction, a data-register write only loads the index. The next data-register read then returns the addressed bit in bit 7. The stored word and its bit 0 are also brought out as ports. Bit 0 is the professional/consumer flag, where 1 means professional. The receiver presents its rate as a one-hot detector vector, and the block encodes it into a two-bit field.

Top module: `cs_access_port`

## Requirements
- R1: After reset the stored word is all zeros, the direction is write, the index is 0 and rdata is 0x00.
- R2: A write to address 0 sets the direction from wdata bit 0: 1 selects read and 0 selects write. Reading address 0 returns the current direction in bit 4.
- R3: In write direction, a write to address 1 stores wdata bit 7 into word bit wdata[4:0]. It also loads the index with wdata[4:0]. No other word bit changes, and wdata bits 6:5 are ignored.
- R4: In read direction, a write to address 1 loads only the index from wdata[4:0]. The stored word is left unchanged.
- R5: A read of address 1 returns the word bit at the current index in bit 7, the index in bits 4:0, and zeros in bits 6:5.
- R6: A read of address 0 returns clock-present in bit 2, data-present in bit 3, the direction in bit 4 and zeros in bits 7:5.
- R7: The rate field is rdata bits 1:0. It reads 01 for a 32 kHz detection (rxRateHot = 001), 10 for 44.1 kHz (010) and 11 for 48 kHz (100). Any other rxRateHot value gives 00. When clock-present is low, the field is 00 whatever rxRateHot holds.
- R8: rdata is registered. It updates on the clock edge at which rdEn is sampled high, showing the state from before that edge, and holds its value while rdEn is low.
- R9: csWord always shows the stored word, and isPro always equals stored bit 0. Thirty-two write-direction writes with indices 0 to 31 reproduce any chosen word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 1 | 0 = control/status, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| clkPresent | input | 1 | Receiver clock detected |
| dataPresent | input | 1 | Receiver data detected |
| rxRateHot | input | 3 | One-hot rate detection {48k, 44.1k, 32k} |
| csWord | output | 32 | Stored channel-status word |
| isPro | output | 1 | Professional flag (word bit 0) |

## Verification
The hardest case to reach from the ports is a data-register write made in read direction. It must move the index but leave the word untouched, and this can only be seen through a later read or through csWord. The stimulus first fills the word with a known pattern. It then switches to read direction and writes indices whose bit 7 disagrees with the stored bit. Afterwards it checks that csWord is unchanged and that each read-back returns the stored bit rather than the written one. A rate vector with several bits set, and a valid vector presented while the clock is absent, cover the two ways the rate field falls to 00.

// File: rtl/cs_port_pkg.sv
package cs_port_pkg;
  typedef struct packed {
    logic setDir;
    logic loadIdx;
    logic storeBit;
    logic readStat;
    logic readData;
  } strobe_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/cs_control.sv
module cs_control
  import cs_port_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    addr,
  input  logic    dirBit,
  output strobe_t stb,
  output logic    dirRead
);
  logic dirQ;

  always_comb begin
    stb          = '0;
    stb.setDir   = wrEn && (addr == ADDR_CTRL);
    stb.loadIdx  = wrEn && (addr == ADDR_DATA);
    stb.storeBit = wrEn && (addr == ADDR_DATA) && !dirQ;
    stb.readStat = rdEn && (addr == ADDR_CTRL);
    stb.readData = rdEn && (addr == ADDR_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirQ <= 1'b0;
    else if (stb.setDir) dirQ <= dirBit;
  end

  assign dirRead = dirQ;

  a_r2_dir_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL) |=> (dirRead == $past(dirBit)));

  a_r4_no_store_in_read_dir: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeBit |-> !dirRead);

  a_r2_dir_kept: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_CTRL) |=> $stable(dirRead));
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_port_pkg::*;
#(
  parameter int CS_BITS = 32,
  parameter int DATA_W  = 8
)(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                dirRead,
  input  logic                clkPresent,
  input  logic                dataPresent,
  input  logic [2:0]          rxRateHot,
  output logic [DATA_W-1:0]   rdata,
  output logic [CS_BITS-1:0]  csWord
);
  localparam int IDX_W   = $clog2(CS_BITS);
  localparam int VAL_BIT = DATA_W - 1;
  localparam int CLK_BIT = 2;
  localparam int DAT_BIT = 3;
  localparam int DIR_BIT = 4;

  logic [CS_BITS-1:0] csQ;
  logic [IDX_W-1:0]   idxQ;
  logic [IDX_W-1:0]   wrIdx;
  logic [1:0]         rateCode;
  logic [DATA_W-1:0]  statusByte;
  logic [DATA_W-1:0]  dataByte;
  logic [DATA_W-1:0]  rdataQ;

  assign wrIdx = wdata[IDX_W-1:0];

  always_comb begin
    unique case (rxRateHot)
      3'b001:  rateCode = 2'b01;
      3'b010:  rateCode = 2'b10;
      3'b100:  rateCode = 2'b11;
      default: rateCode = 2'b00;
    endcase
    if (!clkPresent) rateCode = 2'b00;
  end

  always_comb begin
    statusByte          = '0;
    statusByte[1:0]     = rateCode;
    statusByte[CLK_BIT] = clkPresent;
    statusByte[DAT_BIT] = dataPresent;
    statusByte[DIR_BIT] = dirRead;
  end

  always_comb begin
    dataByte              = '0;
    dataByte[IDX_W-1:0]   = idxQ;
    dataByte[VAL_BIT]     = csQ[idxQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ  <= '0;
      idxQ <= '0;
    end else begin
      if (stb.loadIdx)  idxQ       <= wrIdx;
      if (stb.storeBit) csQ[wrIdx] <= wdata[VAL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdataQ <= '0;
    else if (stb.readStat) rdataQ <= statusByte;
    else if (stb.readData) rdataQ <= dataByte;
  end

  assign rdata  = rdataQ;
  assign csWord = csQ;

  a_r3_bit_stored: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeBit |=> (csWord[$past(wrIdx)] == $past(wdata[VAL_BIT])));

  a_r4_word_kept: assert property (@(posedge clk) disable iff (!rstN)
    !stb.storeBit |=> $stable(csWord));

  a_r7_rate_gated: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readStat && !clkPresent) |=> (rdata[1:0] == 2'b00));

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.readStat || stb.readData) |=> $stable(rdata));

  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.readData |=> (rdata[VAL_BIT-1:IDX_W] == '0));
endmodule

// File: rtl/cs_access_port.sv
module cs_access_port
  import cs_port_pkg::*;
#(
  parameter int CS_BITS = 32,
  parameter int DATA_W  = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic               addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               clkPresent,
  input  logic               dataPresent,
  input  logic [2:0]         rxRateHot,
  output logic [CS_BITS-1:0] csWord,
  output logic               isPro
);
  strobe_t stb;
  logic    dirRead;

  cs_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .dirBit  (wdata[0]),
    .stb     (stb),
    .dirRead (dirRead)
  );

  cs_datapath #(.CS_BITS(CS_BITS), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wdata       (wdata),
    .dirRead     (dirRead),
    .clkPresent  (clkPresent),
    .dataPresent (dataPresent),
    .rxRateHot   (rxRateHot),
    .rdata       (rdata),
    .csWord      (csWord)
  );

  assign isPro = csWord[0];

  a_r9_pro_flag: assert property (@(posedge clk) disable iff (!rstN)
    isPro == csWord[0]);
endmodule

// File: tb/cs_access_port_bench.sv
module cs_access_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        clkPresent = 1'b0;
  logic        dataPresent = 1'b0;
  logic [2:0]  rxRateHot = '0;
  logic [31:0] csWord;
  logic        isPro;

  int errors = 0;
  int checks = 0;
  logic [31:0] modelCs = '0;
  logic [4:0]  modelIdx = '0;
  logic        modelDir = 1'b0;
  logic        rdPendQ = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  cs_access_port u_cs_access_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clkPresent(clkPresent),
    .dataPresent(dataPresent), .rxRateHot(rxRateHot),
    .csWord(csWord), .isPro(isPro)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdPendQ <= rdEn;

  always @(negedge clk) begin
    if (rdPendQ) begin
      if (sbq.size() == 0) check("R8 unexpected read", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, {24'd0, rdata}, {24'd0, it.exp});
      end
    end
  end

  function automatic logic [1:0] rateOf(input logic cp, input logic [2:0] hot);
    if (!cp) return 2'b00;
    case (hot)
      3'b001:  return 2'b01;
      3'b010:  return 2'b10;
      3'b100:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    if (a == 1'b0) modelDir = d[0];
    else begin
      modelIdx = d[4:0];
      if (!modelDir) modelCs[d[4:0]] = d[7];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic a, input string tag);
    item_t it;
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    if (a == 1'b0)
      it.exp = {3'b000, modelDir, dataPresent, clkPresent, rateOf(clkPresent, rxRateHot)};
    else
      it.exp = {modelCs[modelIdx], 2'b00, modelIdx};
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    check("watchdog expired", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csWord", csWord, 32'd0);
    check("R1 rdata", {24'd0, rdata}, 32'd0);
    busRead(1'b1, "R1 idx zero");
    busRead(1'b0, "R1 dir write");

    // R3 single write, upper ignored bits set
    busWrite(1'b0, 8'h00);
    busWrite(1'b1, 8'hE5);            // bit 5 = 1, bits 6:5 ignored
    check("R3 single bit", csWord, 32'h0000_0020);
    busRead(1'b1, "R5 read back idx5");

    // R9 full word update and professional flag
    pat = 32'hA5C3_0F69;
    for (int i = 0; i < 32; i++) busWrite(1'b1, {pat[i], 2'b11, i[4:0]});
    check("R9 full word", csWord, pat);
    check("R9 isPro", {31'd0, isPro}, {31'd0, pat[0]});
    busWrite(1'b1, 8'h00);
    check("R9 isPro cleared", {31'd0, isPro}, 32'd0);
    busWrite(1'b1, 8'h80);
    check("R9 isPro set", {31'd0, isPro}, 32'd1);

    // R2 direction read, R4 index-only writes
    busWrite(1'b0, 8'h01);
    busRead(1'b0, "R2 dir read bit4");
    for (int i = 0; i < 32; i += 3) begin
      busWrite(1'b1, {~modelCs[i], 2'b00, i[4:0]});
      busRead(1'b1, "R5 read dir bit");
    end
    check("R4 word untouched", csWord, modelCs);

    // R8 hold while idle
    begin
      logic [7:0] held;
      busRead(1'b1, "R8 before hold");
      repeat (4) @(negedge clk);
      held = rdata;
      repeat (3) @(negedge clk);
      check("R8 rdata hold", {24'd0, rdata}, {24'd0, held});
    end

    // R6, R7 status decode
    clkPresent = 1'b1; dataPresent = 1'b1;
    rxRateHot = 3'b001; busRead(1'b0, "R7 32k");
    rxRateHot = 3'b010; busRead(1'b0, "R7 44k1");
    rxRateHot = 3'b100; busRead(1'b0, "R7 48k");
    rxRateHot = 3'b110; busRead(1'b0, "R7 multi-hot");
    rxRateHot = 3'b000; busRead(1'b0, "R7 none");
    dataPresent = 1'b0; rxRateHot = 3'b100;
    busRead(1'b0, "R6 data absent");
    clkPresent = 1'b0; dataPresent = 1'b1;
    busRead(1'b0, "R7 clock absent gates rate");
    busWrite(1'b0, 8'hFE);
    busRead(1'b0, "R2 back to write dir");

    // R8 read same cycle as write returns pre-edge state
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 1'b1; wdata = 8'h83;
    begin
      item_t it;
      it.exp = {modelCs[modelIdx], 2'b00, modelIdx};
      it.tag = "R8 pre-edge read";
      sbq.push_back(it);
    end
    modelIdx = 5'd3; modelCs[3] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    busRead(1'b1, "R3 after combined access");
    check("R3 combined store", csWord, modelCs);

    repeat (3) @(negedge clk);
    check("queue drained", sbq.size(), 32'd0);
    finishRun();
  end
endmodule